// File: doc/BRIEF.md
# Four-Bit ALU with Condition Codes

This block is a purely combinational arithmetic-logic unit for a narrow datapath. It takes two operands and a four-bit function code and produces a result together with four condition flags. Because it holds no state, its result can be routed straight back to a register-file write port in the same cycle in which its operands are read.

The function code has two parts. The upper two bits are operand modifiers: one complements A, and the other negates B by complementing it and forcing a carry into the adder. The lower two bits choose the operation: AND, OR, add, or set-less-than. Combining the two parts gives several operations from one adder:

- subtract (`0110`);
- NOR (`1100`) and NAND-style forms;
- a signed comparison (`0111`).

Top module: `alu_cc_core`

## Requirements
- R1: With func[1:0]=00 the result is the bitwise AND of the modified operands, and with func[1:0]=01 it is their bitwise OR. The modified A is ~a when func[3]=1, else a. The modified B is ~b when func[2]=1, else b. For example, func 1100 gives ~a & ~b.
- R2: Function code 0010 gives result = (a + b) mod 16.
- R3: Function code 0110 gives result = (a - b) mod 16.
- R4: func[3]=1 complements A before the operation. With code 1010 and a=b=0, the result is 1111.
- R5: Function code 0111 gives result 0001 when a < b as two's-complement values, and 0000 otherwise. For example, a=1111 and b=0000 give 0001.
- R6: Any code with func[1:0]=11 gives 0001 when the exact signed sum of the modified operands and the carry-in is negative, and 0000 otherwise. This is the adder sign XOR the adder overflow. For example, code 0011 with a=0111 and b=0001 gives 0000.
- R7: flag_zero is 1 exactly when the result is 0000.
- R8: flag_neg equals result bit 3.
- R9: flag_carry is the carry out of bit 3 of the adder when func[1:0]=10, and 0 for every other operation. For subtract, 1 means a >= b unsigned.
- R10: flag_ovf is 1 when func[1:0]=10 and the signed sum of the modified operands plus carry-in lies outside -8..7. It is 0 for every other operation.
- R11: Every output is a combinational function of the present inputs, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 4 | Operand A |
| b | input | 4 | Operand B |
| func | input | 4 | Function code: [3] complement A, [2] negate B, [1:0] operation |
| result | output | 4 | Operation result |
| flag_zero | output | 1 | Result is zero |
| flag_neg | output | 1 | Result bit 3 |
| flag_carry | output | 1 | Adder carry out (add-type operations only) |
| flag_ovf | output | 1 | Adder signed overflow (add-type operations only) |

## Verification
Add, subtract and signed compare are each swept over all 256 operand pairs. These sweeps separate modular wrap, borrow direction and the sign-versus-overflow correction of the comparison: a compare that uses only the sign bit fails on pairs such as 0111 against 1000. The logic operations are driven with complementary nibble patterns under all four modifier settings, which shows whether each complement is applied to the correct operand. A final sweep covers every function code against every operand pair and checks all four flags. That sweep shows that carry and overflow appear only for add-type codes and that the flags follow the 0/1 result of set-less-than.

// File: rtl/alu_cc_pkg.sv
// Package: shared types for the condition-code ALU.
// Assumes a four-bit function code: [3] complement A, [2] negate B, [1:0] operation.
package alu_cc_pkg;

    localparam int FUNC_W = 4;

    typedef enum logic [1:0] {
        OP_AND = 2'b00,
        OP_OR  = 2'b01,
        OP_ADD = 2'b10,
        OP_SLT = 2'b11
    } alu_op_e;

    typedef struct packed {
        logic    inv_a;
        logic    neg_b;
        alu_op_e op;
    } alu_func_t;

endpackage

// File: rtl/alu_cc_operand.sv
// Operand conditioner: applies the optional complement of A and negation of B.
// Negation is expressed as a complemented B plus a carry-in of one for the adder.
// Assumes the caller applies carry_in only on the adder path.
module alu_cc_operand #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         inv_a,
    input  logic         neg_b,
    output logic [W-1:0] a_mod,
    output logic [W-1:0] b_mod,
    output logic         carry_in
);

    // Purpose: select the true or complemented form of each operand.
    always_comb begin
        a_mod    = inv_a ? ~a : a;
        b_mod    = neg_b ? ~b : b;
        carry_in = neg_b;
    end

endmodule

// File: rtl/alu_cc_adder.sv
// Ripple adder built from a generated chain of full adders.
// Reports the carry out of the top bit and the signed overflow.
// Assumes W >= 2.
module alu_cc_adder #(
    parameter int W = 4
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);

    logic [W:0] chain;

    assign chain[0] = cin;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // Purpose: one full-adder stage of the ripple chain.
        always_comb begin
            sum[i]     = x[i] ^ y[i] ^ chain[i];
            chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
        end
    end

    // Purpose: carry out, and overflow as disagreement of the carries around the sign bit.
    always_comb begin
        cout = chain[W];
        ovf  = chain[W] ^ chain[W-1];
    end

endmodule

// File: rtl/alu_cc_flags.sv
// Condition-code generator.
// Zero and negative follow the final result. Carry and overflow pass only for the add operation.
module alu_cc_flags
    import alu_cc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0] res,
    input  alu_op_e      op,
    input  logic         add_cout,
    input  logic         add_ovf,
    output logic         zero,
    output logic         neg,
    output logic         carry,
    output logic         ovf
);

    // Purpose: derive the four condition flags from the result and the adder status.
    always_comb begin
        zero  = (res == '0);
        neg   = res[W-1];
        carry = (op == OP_ADD) & add_cout;
        ovf   = (op == OP_ADD) & add_ovf;
    end

endmodule

// File: rtl/alu_cc_core.sv
// Top of the condition-code ALU. It is purely combinational and has no clock or reset.
// Decodes the function code, conditions the operands, runs one shared adder,
// and selects AND, OR, sum or the signed less-than bit.
module alu_cc_core
    import alu_cc_pkg::*;
#(
    parameter int W = 4
) (
    input  logic [W-1:0]      a,
    input  logic [W-1:0]      b,
    input  logic [FUNC_W-1:0] func,
    output logic [W-1:0]      result,
    output logic              flag_zero,
    output logic              flag_neg,
    output logic              flag_carry,
    output logic              flag_ovf
);

    alu_func_t   fn;
    logic [W-1:0] a_mod, b_mod, sum;
    logic         cin, cout, aovf, less;

    assign fn = alu_func_t'(func);

    alu_cc_operand #(.W(W)) u_operand (
        .a(a), .b(b), .inv_a(fn.inv_a), .neg_b(fn.neg_b),
        .a_mod(a_mod), .b_mod(b_mod), .carry_in(cin)
    );

    alu_cc_adder #(.W(W)) u_adder (
        .x(a_mod), .y(b_mod), .cin(cin),
        .sum(sum), .cout(cout), .ovf(aovf)
    );

    // Purpose: choose the operation result; the less-than bit corrects the sign by the overflow.
    always_comb begin
        less = sum[W-1] ^ aovf;
        unique case (fn.op)
            OP_AND:  result = a_mod & b_mod;
            OP_OR:   result = a_mod | b_mod;
            OP_ADD:  result = sum;
            default: result = {{(W-1){1'b0}}, less};
        endcase
    end

    alu_cc_flags #(.W(W)) u_flags (
        .res(result), .op(fn.op), .add_cout(cout), .add_ovf(aovf),
        .zero(flag_zero), .neg(flag_neg), .carry(flag_carry), .ovf(flag_ovf)
    );

endmodule

// Checker: immediate checks of the port-level relations of the ALU.
module alu_cc_checker #(
    parameter int W = 4
) (
    input logic [W-1:0] a,
    input logic [W-1:0] b,
    input logic [3:0]   func,
    input logic [W-1:0] result,
    input logic         flag_zero,
    input logic         flag_neg,
    input logic         flag_carry,
    input logic         flag_ovf
);

    logic [W-1:0] exp_add, exp_sub;
    logic         exp_lt;

    // Purpose: compute independent expectations and compare them with the outputs.
    always_comb begin
        exp_add = a + b;
        exp_sub = a - b;
        exp_lt  = ($signed(a) < $signed(b));
        a_r7_zero_flag: assert (flag_zero == (result == '0))
            else $error("zero flag disagrees with result");
        a_r8_neg_flag: assert (flag_neg == result[W-1])
            else $error("negative flag disagrees with result");
        a_r2_add: assert (func != 4'b0010 || result == exp_add)
            else $error("add result wrong");
        a_r3_sub: assert (func != 4'b0110 || result == exp_sub)
            else $error("subtract result wrong");
        a_r5_slt_signed: assert (func != 4'b0111 || result == {{(W-1){1'b0}}, exp_lt})
            else $error("signed compare wrong");
        a_r6_slt_binary: assert (func[1:0] != 2'b11 || result[W-1:1] == '0)
            else $error("set-less-than result not 0/1");
        a_r9_carry_gated: assert (func[1:0] == 2'b10 || !flag_carry)
            else $error("carry outside add-type op");
        a_r10_ovf_gated: assert (func[1:0] == 2'b10 || !flag_ovf)
            else $error("overflow outside add-type op");
    end

endmodule

bind alu_cc_core alu_cc_checker #(.W(W)) u_alu_cc_checker (
    .a(a), .b(b), .func(func), .result(result),
    .flag_zero(flag_zero), .flag_neg(flag_neg),
    .flag_carry(flag_carry), .flag_ovf(flag_ovf)
);

// File: tb/alu_cc_core_test.sv
// Directed bench for the condition-code ALU, one task per scenario.
module alu_cc_core_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] a, b, func;
    logic [3:0] result;
    logic       flag_zero, flag_neg, flag_carry, flag_ovf;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    alu_cc_core uut (
        .a(a), .b(b), .func(func), .result(result),
        .flag_zero(flag_zero), .flag_neg(flag_neg),
        .flag_carry(flag_carry), .flag_ovf(flag_ovf)
    );

    // Apply inputs after a falling edge and let them settle before sampling.
    task automatic apply(input logic [3:0] fa, input logic [3:0] fb, input logic [3:0] ff);
        @(negedge clk);
        a = fa; b = fb; func = ff;
        #2;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s a=%b b=%b func=%b actual=%h expected=%h", req, a, b, func, act, exp);
        end
    endtask

    // Reference model written from the requirements.
    task automatic model(input logic [3:0] ma, input logic [3:0] mb, input logic [3:0] mf,
                         output logic [3:0] r, output logic z, output logic n,
                         output logic c, output logic v);
        logic [3:0] ae, be;
        int ci, s, sa, sb, ss;
        ae = mf[3] ? ~ma : ma;
        be = mf[2] ? ~mb : mb;
        ci = mf[2] ? 1 : 0;
        s  = int'(ae) + int'(be) + ci;
        sa = ae[3] ? int'(ae) - 16 : int'(ae);
        sb = be[3] ? int'(be) - 16 : int'(be);
        ss = sa + sb + ci;
        c = 1'b0; v = 1'b0;
        case (mf[1:0])
            2'b00: r = ae & be;
            2'b01: r = ae | be;
            2'b10: begin r = s[3:0]; c = (s > 15); v = (ss < -8) || (ss > 7); end
            default: r = (ss < 0) ? 4'd1 : 4'd0;
        endcase
        z = (r == 4'd0);
        n = r[3];
    endtask

    task automatic t_idle;   // R11: outputs follow inputs with no clocking of the block
        apply(4'd0, 4'd0, 4'b0000);
        check("R11 idle result", {4'd0, result}, 8'h00);
        check("R7 idle zero", {7'd0, flag_zero}, 8'h01);
        a = 4'b1010; b = 4'b0110; #1;
        check("R11 no-clock update", {4'd0, result}, 8'h02);
    endtask

    task automatic t_logic;   // R1
        apply(4'b1100, 4'b1010, 4'b0000); check("R1 and", {4'd0, result}, 8'h08);
        apply(4'b1100, 4'b1010, 4'b0001); check("R1 or", {4'd0, result}, 8'h0e);
        apply(4'b1100, 4'b1010, 4'b1100); check("R1 nor", {4'd0, result}, 8'h01);
        apply(4'b1100, 4'b1010, 4'b1101); check("R1 nand", {4'd0, result}, 8'h07);
        apply(4'b1100, 4'b1010, 4'b0100); check("R1 and ~b", {4'd0, result}, 8'h04);
        apply(4'b1100, 4'b1010, 4'b1000); check("R1 ~a and b", {4'd0, result}, 8'h02);
    endtask

    task automatic t_add;   // R2
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                apply(4'(i), 4'(j), 4'b0010);
                check("R2 add", {4'd0, result}, 8'((i + j) % 16));
            end
    endtask

    task automatic t_sub;   // R3
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                apply(4'(i), 4'(j), 4'b0110);
                check("R3 sub", {4'd0, result}, 8'((i - j + 16) % 16));
                check("R9 sub carry", {7'd0, flag_carry}, {7'd0, (i >= j)});
            end
    endtask

    task automatic t_invert_a;   // R4
        apply(4'd0, 4'd0, 4'b1010);
        check("R4 minus one", {4'd0, result}, 8'h0f);
        check("R8 minus one neg", {7'd0, flag_neg}, 8'h01);
    endtask

    task automatic t_slt_signed;   // R5
        apply(4'b1111, 4'b0000, 4'b0111); check("R5 -1<0", {4'd0, result}, 8'h01);
        apply(4'b0111, 4'b1000, 4'b0111); check("R5 7<-8", {4'd0, result}, 8'h00);
        apply(4'b1000, 4'b0111, 4'b0111); check("R5 -8<7", {4'd0, result}, 8'h01);
        for (int i = 0; i < 16; i++)
            for (int j = 0; j < 16; j++) begin
                int si, sj;
                si = (i > 7) ? i - 16 : i;
                sj = (j > 7) ? j - 16 : j;
                apply(4'(i), 4'(j), 4'b0111);
                check("R5 slt sweep", {4'd0, result}, {7'd0, (si < sj)});
            end
    endtask

    task automatic t_slt_sum;   // R6
        apply(4'b0111, 4'b0001, 4'b0011); check("R6 7+1 not neg", {4'd0, result}, 8'h00);
        apply(4'b1000, 4'b1111, 4'b0011); check("R6 -8-1 neg", {4'd0, result}, 8'h01);
        apply(4'b0010, 4'b1101, 4'b0011); check("R6 2-3 neg", {4'd0, result}, 8'h01);
    endtask

    task automatic t_flags;   // R7 R8 R9 R10 over every code and pair
        for (int f = 0; f < 16; f++)
            for (int i = 0; i < 16; i++)
                for (int j = 0; j < 16; j++) begin
                    logic [3:0] er;
                    logic ez, en, ec, ev;
                    model(4'(i), 4'(j), 4'(f), er, ez, en, ec, ev);
                    apply(4'(i), 4'(j), 4'(f));
                    check("R1 R6 model result", {4'd0, result}, {4'd0, er});
                    check("R7 zero", {7'd0, flag_zero}, {7'd0, ez});
                    check("R8 neg", {7'd0, flag_neg}, {7'd0, en});
                    check("R9 carry", {7'd0, flag_carry}, {7'd0, ec});
                    check("R10 ovf", {7'd0, flag_ovf}, {7'd0, ev});
                end
    endtask

    initial begin
        a = '0; b = '0; func = '0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        t_idle();
        t_logic();
        t_add();
        t_sub();
        t_invert_a();
        t_slt_signed();
        t_slt_sum();
        t_flags();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule